// File: doc/BRIEF.md
# Walking-Pattern RAM Self-Test Engine

This block is a self-test controller for a synchronous single-port RAM. After a start pulse it takes over the RAM port. It writes one test word at a time, reads the same location back on the next cycle, and compares the returned word with what it wrote. The data width and the address width are parameters. The test covers the whole address range.

Four phases run in a fixed order:
- uniform all-zeros,
- uniform all-ones,
- walking ones,
- walking zeros.

The two uniform phases expose bits that are stuck at one level. The walking phases expose data lines that are shorted together. On the first mismatch the engine stops. It raises a fail flag and holds the failing address, the word it expected and the word it observed, so that software or a tester can read which lines are involved. A run without any fault ends with done high and fail low.

The RAM is expected to return read data one clock after the read is issued. Every test word therefore takes three cycles:
1. write,
2. read,
3. compare.

Top module: `mem_pattern_bist`

## Requirements
- R1: After reset, busy, done, fail and mem_we are all 0.
- R2: The phases run in the order all-zeros, all-ones, walking ones, walking zeros. Each phase visits addresses 0 to 2^AW-1 in ascending order. A uniform phase writes one word per address. A walking phase writes DW words per address. Each word takes exactly 3 busy cycles (write, read, compare), so a fault-free run is busy for 3*2^AW*(2+2*DW) cycles.
- R3: In the walking-ones phase, the word for step k (k = 0 up to DW-1) has only bit k set, and bit 0 is the least significant bit.
- R4: In the walking-zeros phase, the word for step k is the bitwise complement of the walking-ones word: only bit k is 0.
- R5: A write cycle (mem_we=1) is followed by one read cycle at the same address with mem_we=0. The read data is compared on the cycle after the read.
- R6: On the first mismatch the engine does the following:
  - sets fail;
  - captures fail_addr, fail_exp (the word written) and fail_obs (the word read);
  - drops busy and raises done in the cycle after the compare;
  - issues no further writes.
- R7: A fault-free run ends with done=1 and fail=0.
- R8: A start pulse while busy is ignored. The run continues and its length is unchanged.
- R9: done, fail and the captured values hold until the next start. A start from the done state clears fail and begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; honoured only when not busy |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DW | RAM read data, valid one cycle after the read |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished (pass or fail) |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Word written at the failing step |
| fail_obs | output | DW | Word read back at the failing step |

## Verification
The embedded assertions check the following on every cycle:
- writes happen only while busy;
- every write is followed by a non-writing read at the same address;
- busy and done are exclusive;
- the walking words carry exactly one set bit (walking ones) or exactly one cleared bit (walking zeros);
- done and the captured data are held stable while no start arrives.

Only the bench scenarios can show the remaining behaviour. These are the full write order against an independent model, the exact run length, and that an ignored start leaves that length unchanged. They also show that faulty RAMs are caught at the right step with the right captured words: wired-OR shorted data lines, where the observed word shows both lines, and cells stuck at 0 or at 1.

// File: rtl/mem_pattern_bist.sv
module mem_pattern_bist #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_obs
);
  localparam int SW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [SW-1:0] STEP_LAST = SW'(DW - 1);
  localparam logic [1:0] PH_ZERO = 2'd0, PH_ONE = 2'd1, PH_W1 = 2'd2, PH_W0 = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_CMP, S_END} state_t;

  state_t        state;
  logic [1:0]    phase;
  logic [SW-1:0] step;
  logic [AW-1:0] addr;
  logic [DW-1:0] pat;
  logic [DW-1:0] bitmask;

  assign bitmask = DW'(1) << step;

  always_comb begin
    case (phase)
      PH_ZERO: pat = '0;
      PH_ONE:  pat = '1;
      PH_W1:   pat = bitmask;
      default: pat = ~bitmask;
    endcase
  end

  assign mem_addr  = addr;
  assign mem_wdata = pat;
  assign mem_we    = (state == S_WR);
  assign busy      = (state == S_WR) || (state == S_RD) || (state == S_CMP);
  assign done      = (state == S_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= PH_ZERO;
      step      <= '0;
      addr      <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else begin
      case (state)
        S_IDLE, S_END: begin
          if (start) begin
            state     <= S_WR;
            phase     <= PH_ZERO;
            step      <= '0;
            addr      <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_obs  <= '0;
          end
        end
        S_WR: state <= S_RD;
        S_RD: state <= S_CMP;
        S_CMP: begin
          if (mem_rdata != pat) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_exp  <= pat;
            fail_obs  <= mem_rdata;
            state     <= S_END;
          end else if (phase[1] && step != STEP_LAST) begin
            step  <= step + 1'b1;
            state <= S_WR;
          end else begin
            step <= '0;
            if (addr != '1) begin
              addr  <= addr + 1'b1;
              state <= S_WR;
            end else begin
              addr <= '0;
              if (phase == PH_W0) begin
                state <= S_END;
              end else begin
                phase <= phase + 1'b1;
                state <= S_WR;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && busy && mem_addr == $past(mem_addr))); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R6
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (done && !mem_we)); // R6
  AST_WALK1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && phase == PH_W1) |-> ($countones(mem_wdata) == 1)); // R3
  AST_WALK0_ONECOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && phase == PH_W0) |-> ($countones(~mem_wdata) == 1)); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_addr)
                          && $stable(fail_exp) && $stable(fail_obs))); // R9
endmodule

// File: tb/mem_pattern_bist_tb.sv
module mem_pattern_bist_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int FULL_CYC = 3 * N * (2 + 2 * DW);

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_obs;
  logic mem_we, busy, done, fail;

  int checks = 0, failures = 0;
  int fmode = 0, fa = 0, fb = 0, fsa = 0, fk = 0;
  int wr_idx = 0, wr_err = 0;
  logic [DW-1:0] ram [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_pattern_bist #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs));

  function automatic logic [DW-1:0] stored(input logic [DW-1:0] w, input int a);
    logic [DW-1:0] s = w;
    if (fmode == 1 && (w[fa] | w[fb])) begin s[fa] = 1'b1; s[fb] = 1'b1; end
    if (fmode == 2 && a == fsa) s[fk] = 1'b0;
    if (fmode == 3 && a == fsa) s[fk] = 1'b1;
    return s;
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= stored(mem_wdata, int'(mem_addr));
    mem_rdata <= ram[mem_addr];
  end

  function automatic logic [DW-1:0] exp_word(input int idx);
    int j;
    if (idx < N) return '0;
    if (idx < 2 * N) return '1;
    j = idx - 2 * N;
    if (j < N * DW) return DW'(1) << (j % DW);
    j = j - N * DW;
    return ~(DW'(1) << (j % DW));
  endfunction

  function automatic int exp_addr(input int idx);
    if (idx < 2 * N) return idx % N;
    return ((idx - 2 * N) % (N * DW)) / DW;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (mem_wdata != exp_word(wr_idx) || int'(mem_addr) != exp_addr(wr_idx)) wr_err++;
      wr_idx++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run(input int mid_start, output int cyc);
    cyc = 0;
    wr_idx = 0; wr_err = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy && !fail && !done, "R9 start clears fail and begins run", {busy, fail, done}, 3'b100);
    while (busy && cyc < 5000) begin
      cyc++;
      if (cyc == mid_start) start = 1;
      @(negedge clk);
      start = 0;
    end
    chk(done, "R6/R7 done at end of run", done, 1);
    chk(wr_err == 0, "R2 R3 R4 write order and words", wr_err, 0);
  endtask

  task automatic fault_run(input int mode, input int a, input int b, input int sa, input int k);
    int cyc, exp_cyc;
    logic [AW-1:0] ea;
    logic [DW-1:0] ee, eo;
    fmode = mode; fa = a; fb = b; fsa = sa; fk = k;
    case (mode)
      1: begin ea = '0; ee = DW'(1) << a; eo = ee | (DW'(1) << b); exp_cyc = 3 * (2 * N + a + 1); end
      2: begin ea = AW'(sa); ee = '1; eo = ~(DW'(1) << k); exp_cyc = 3 * (N + sa + 1); end
      default: begin ea = AW'(sa); ee = '0; eo = DW'(1) << k; exp_cyc = 3 * (sa + 1); end
    endcase
    run(0, cyc);
    chk(fail, "R6 fail raised", fail, 1);
    chk(fail_addr == ea, "R6 fail_addr", fail_addr, ea);
    chk(fail_exp == ee, "R6 fail_exp", fail_exp, ee);
    chk(fail_obs == eo, "R6 fail_obs", fail_obs, eo);
    chk(cyc == exp_cyc, "R6 stops at first mismatch", cyc, exp_cyc);
    repeat (4) @(negedge clk);
    chk(done && fail && fail_obs == eo && !mem_we, "R9 results held", fail_obs, eo);
  endtask

  initial begin
    int cyc, a, b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_we, "R1 reset state", {busy, done, fail, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !fail, "R1 idle after reset", {busy, done, fail}, 0);

    fmode = 0;
    run(0, cyc);
    chk(!fail, "R7 fault-free passes", fail, 0);
    chk(cyc == FULL_CYC, "R2 run length", cyc, FULL_CYC);

    run(100, cyc);
    chk(cyc == FULL_CYC, "R8 start while busy ignored", cyc, FULL_CYC);
    chk(!fail, "R8 run unaffected", fail, 0);

    fault_run(1, 0, DW - 1, 0, 0);
    fault_run(3, 0, 0, N - 1, 0);
    fault_run(2, 0, 0, 0, DW - 1);

    for (int t = 0; t < 6; t++) begin
      a = $urandom_range(DW - 2, 0);
      b = $urandom_range(DW - 1, a + 1);
      fault_run(1, a, b, 0, 0);
      fault_run(2 + (t % 2), 0, 0, $urandom_range(N - 1, 0), $urandom_range(DW - 1, 0));
    end

    fmode = 0;
    run(0, cyc);
    chk(!fail && cyc == FULL_CYC, "R7 R9 clean rerun after fault", cyc, FULL_CYC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule